// File: doc/BRIEF.md
# Virtual Channel Link Multiplexer

This block shares one physical output link among several virtual channels (VCs). Each VC has a small private flit queue that is filled from its own upstream write port. On every clock cycle the block picks one VC that both holds a flit and has room downstream, sends that flit on the link, and tags it with the VC number. Flits from different packets therefore interleave cycle by cycle. A packet whose VC is blocked downstream does not hold up packets on other VCs.

Selection among eligible VCs is round-robin, so two VCs with traffic take turns on the link. The block also tracks packet boundaries per VC, from the flit type of each flit it sends. It reports which VCs currently have a packet open on the link. The default is three VCs, each with a three-flit queue.

Top module: `vc_link_mux`

## Requirements
- R1: After reset, `link_valid` is low, every `in_ready` bit is high, every `pkt_open` bit is low, and every queue is empty.
- R2: Flits of one VC leave on the link in the order they were accepted. No flit is lost, duplicated or reordered.
- R3: A queue holding DEPTH flits drives its `in_ready` bit low. A write to a full queue is dropped, and `wr_err` for that VC is high in the same cycle. This holds even if the queue sends a flit in that cycle.
- R4: A VC may send only when its queue is non-empty and its `ds_ready` bit is high in that cycle.
- R5: Arbitration is round-robin. The search starts at the VC after the one granted last, and wraps from NUM_VC-1 to 0. Before the first grant, the search starts at VC 0.
- R6: A VC that is not ready downstream never stalls the link. If any VC is eligible, `link_valid` is high.
- R7: `link_valid` is low in any cycle in which no VC is eligible.
- R8: Each flit is FLIT_W = 2 + PAYLOAD_W bits wide. The type occupies bits [FLIT_W-1:FLIT_W-2] and the payload occupies the low bits. Type encoding: 00 body, 01 head, 10 tail, 11 head-and-tail. The link shows the sending VC's number on `link_vc`, plus that flit's type and payload unchanged.
- R9: Sending a head (01) on a VC sets that VC's `pkt_open` from the next cycle. Sending a tail (10) clears it. Body (00) and head-and-tail (11) leave it unchanged.
- R10: A write and a send on the same non-full queue in the same cycle are both performed, and the queue's occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NUM_VC | Per-VC write strobe |
| in_flit | input | NUM_VC*FLIT_W | Per-VC write flit; VC v uses slice [v*FLIT_W +: FLIT_W] |
| in_ready | output | NUM_VC | Per-VC queue not full |
| wr_err | output | NUM_VC | Write attempted to a full queue this cycle |
| ds_ready | input | NUM_VC | Per-VC downstream space available |
| link_valid | output | 1 | A flit is on the link this cycle |
| link_vc | output | VC_W | VC tag of the link flit |
| link_type | output | 2 | Flit type of the link flit |
| link_payload | output | PAYLOAD_W | Payload of the link flit |
| pkt_open | output | NUM_VC | Per-VC packet started but not yet ended on the link |

## Verification
A queue can be written and read in the same cycle. This is the collision that matters most. On a partly filled queue, both actions must take effect and the occupancy must stay the same. On a full queue, the write must still be refused and flagged even though a slot frees in that very cycle. The bench provokes both cases with bursts of writes while downstream readiness toggles at random, and with a directed phase that fills every queue and then opens the downstream side. Each cycle it compares the link outputs, `in_ready`, `wr_err` and `pkt_open` with a queue-and-pointer model kept in the bench.

// File: rtl/vc_link_pkg.sv
package vc_link_pkg;
  typedef enum logic [1:0] {
    FT_BODY = 2'b00,
    FT_HEAD = 2'b01,
    FT_TAIL = 2'b10,
    FT_SOLO = 2'b11
  } flit_kind_e;

  function automatic logic opens_packet(input logic [1:0] t);
    return t == FT_HEAD;
  endfunction

  function automatic logic closes_packet(input logic [1:0] t);
    return t == FT_TAIL;
  endfunction

  function automatic int rr_after(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/vc_flit_queue.sv
module vc_flit_queue #(
  parameter int W     = 10,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = slots[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) begin
        slots[wr_ptr] <= din;
        wr_ptr        <= bump(wr_ptr);
      end
      if (do_pop) rd_ptr <= bump(rd_ptr);
      if (do_push && !do_pop) count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/vc_rr_arbiter.sv
module vc_rr_arbiter #(
  parameter int N   = 3,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] grant_idx,
  output logic             any_grant
);
  import vc_link_pkg::*;

  logic [IDX_W-1:0] start_ptr;

  always_comb begin
    grant     = '0;
    grant_idx = '0;
    any_grant = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(start_ptr) + k) % N;
      if (!any_grant && req[idx]) begin
        any_grant  = 1'b1;
        grant[idx] = 1'b1;
        grant_idx  = idx[IDX_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) start_ptr <= '0;
    else if (any_grant) begin
      int nxt;
      nxt = rr_after(int'(grant_idx), N);
      start_ptr <= nxt[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/vc_pkt_tracker.sv
module vc_pkt_tracker #(
  parameter int N     = 3,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [IDX_W-1:0] fire_vc,
  input  logic [1:0]       fire_type,
  output logic [N-1:0]     open
);
  import vc_link_pkg::*;

  for (genvar v = 0; v < N; v++) begin : g_trk
    logic hit;
    assign hit = fire && (fire_vc == IDX_W'(v));
    always_ff @(posedge clk) begin
      if (!rst_n) open[v] <= 1'b0;
      else if (hit && opens_packet(fire_type)) open[v] <= 1'b1;
      else if (hit && closes_packet(fire_type)) open[v] <= 1'b0;
    end
  end
endmodule

// File: rtl/vc_link_mux.sv
module vc_link_mux #(
  parameter int NUM_VC    = 3,
  parameter int DEPTH     = 3,
  parameter int PAYLOAD_W = 8,
  parameter int FLIT_W    = PAYLOAD_W + 2,
  parameter int VC_W      = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_VC-1:0]        in_valid,
  input  logic [NUM_VC*FLIT_W-1:0] in_flit,
  output logic [NUM_VC-1:0]        in_ready,
  output logic [NUM_VC-1:0]        wr_err,
  input  logic [NUM_VC-1:0]        ds_ready,
  output logic                     link_valid,
  output logic [VC_W-1:0]          link_vc,
  output logic [1:0]               link_type,
  output logic [PAYLOAD_W-1:0]     link_payload,
  output logic [NUM_VC-1:0]        pkt_open
);
  logic [FLIT_W-1:0] q_head [NUM_VC];
  logic [NUM_VC-1:0] q_empty, q_full, eligible, vc_grant;
  logic [VC_W-1:0]   sel_vc;
  logic              sel_any;
  logic [FLIT_W-1:0] sel_flit;

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    vc_flit_queue #(.W(FLIT_W), .DEPTH(DEPTH)) u_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (in_valid[v]),
      .din   (in_flit[v*FLIT_W +: FLIT_W]),
      .pop   (vc_grant[v]),
      .dout  (q_head[v]),
      .empty (q_empty[v]),
      .full  (q_full[v])
    );
  end

  assign eligible = ~q_empty & ds_ready;
  assign in_ready = ~q_full;
  assign wr_err   = in_valid & q_full;

  vc_rr_arbiter #(.N(NUM_VC), .IDX_W(VC_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (eligible),
    .grant     (vc_grant),
    .grant_idx (sel_vc),
    .any_grant (sel_any)
  );

  assign sel_flit     = q_head[sel_vc];
  assign link_valid   = sel_any;
  assign link_vc      = sel_vc;
  assign link_type    = sel_flit[FLIT_W-1 -: 2];
  assign link_payload = sel_flit[PAYLOAD_W-1:0];

  vc_pkt_tracker #(.N(NUM_VC), .IDX_W(VC_W)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (sel_any),
    .fire_vc   (sel_vc),
    .fire_type (link_type),
    .open      (pkt_open)
  );
endmodule

// File: rtl/vc_link_mux_chk.sv
module vc_link_mux_chk #(
  parameter int NUM_VC = 3,
  parameter int VC_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_VC-1:0] in_valid,
  input logic [NUM_VC-1:0] in_ready,
  input logic [NUM_VC-1:0] wr_err,
  input logic [NUM_VC-1:0] ds_ready,
  input logic [NUM_VC-1:0] q_empty,
  input logic [NUM_VC-1:0] vc_grant,
  input logic              link_valid,
  input logic [VC_W-1:0]   link_vc,
  input logic [1:0]        link_type,
  input logic [NUM_VC-1:0] pkt_open
);
  p_grant_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vc_grant));

  p_busy_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~q_empty & ds_ready)) |-> link_valid);

  p_idle_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(~q_empty & ds_ready)) |-> !link_valid);

  for (genvar v = 0; v < NUM_VC; v++) begin : g_chk
    p_send_needs_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (link_valid && link_vc == VC_W'(v)) |-> (ds_ready[v] && !q_empty[v]));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[v] && !in_ready[v]) |-> wr_err[v]);

    p_head_opens_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (link_valid && link_vc == VC_W'(v) && link_type == 2'b01) |=> pkt_open[v]);

    p_tail_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (link_valid && link_vc == VC_W'(v) && link_type == 2'b10) |=> !pkt_open[v]);
  end
endmodule

bind vc_link_mux vc_link_mux_chk #(.NUM_VC(NUM_VC), .VC_W(VC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .wr_err     (wr_err),
  .ds_ready   (ds_ready),
  .q_empty    (q_empty),
  .vc_grant   (vc_grant),
  .link_valid (link_valid),
  .link_vc    (link_vc),
  .link_type  (link_type),
  .pkt_open   (pkt_open)
);

// File: tb/vc_link_mux_bench.sv
module vc_link_mux_bench;
  localparam int NV = 3;
  localparam int DP = 3;
  localparam int PW = 8;
  localparam int FW = PW + 2;
  localparam int VW = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NV-1:0]     in_valid = '0;
  logic [NV*FW-1:0]  in_flit = '0;
  logic [NV-1:0]     in_ready, wr_err, pkt_open;
  logic [NV-1:0]     ds_ready = '0;
  logic              link_valid;
  logic [VW-1:0]     link_vc;
  logic [1:0]        link_type;
  logic [PW-1:0]     link_payload;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [FW-1:0] mbuf [NV][DP];
  int            mcnt [NV];
  int            mptr;
  logic [NV-1:0] mopen;

  always #4 clk = ~clk;

  vc_link_mux #(.NUM_VC(NV), .DEPTH(DP), .PAYLOAD_W(PW)) u_vc_link_mux (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
    .in_ready(in_ready), .wr_err(wr_err), .ds_ready(ds_ready),
    .link_valid(link_valid), .link_vc(link_vc), .link_type(link_type),
    .link_payload(link_payload), .pkt_open(pkt_open)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // round-robin pick from the model pointer; -1 when nothing eligible
  function automatic int model_pick();
    for (int k = 0; k < NV; k++) begin
      int v;
      v = (mptr + k) % NV;
      if (mcnt[v] > 0 && ds_ready[v]) return v;
    end
    return -1;
  endfunction

  task automatic step_and_check();
    int g;
    logic [FW-1:0] f;
    #1;
    g = model_pick();
    chk(link_valid == (g >= 0), "R6/R7 link_valid", int'(link_valid), int'(g >= 0));
    if (g >= 0 && link_valid) begin
      f = mbuf[g][0];
      chk(int'(link_vc) == g, "R5 link_vc", int'(link_vc), g);
      chk({link_type, link_payload} == f, "R2/R8 flit", int'({link_type, link_payload}), int'(f));
    end
    for (int v = 0; v < NV; v++) begin
      chk(in_ready[v] == (mcnt[v] < DP), "R3 in_ready", int'(in_ready[v]), int'(mcnt[v] < DP));
      chk(wr_err[v] == (in_valid[v] && mcnt[v] == DP), "R3 wr_err", int'(wr_err[v]),
          int'(in_valid[v] && mcnt[v] == DP));
    end
    chk(pkt_open == mopen, "R9 pkt_open", int'(pkt_open), int'(mopen));
    // model update for the coming edge (R10: push uses occupancy before pop)
    for (int v = 0; v < NV; v++) begin
      bit full_before;
      full_before = (mcnt[v] == DP);
      if (v == g) begin
        f = mbuf[g][0];
        for (int i = 0; i < DP - 1; i++) mbuf[v][i] = mbuf[v][i+1];
        mcnt[v]--;
        if (f[FW-1 -: 2] == 2'b01) mopen[v] = 1'b1;
        else if (f[FW-1 -: 2] == 2'b10) mopen[v] = 1'b0;
      end
      if (in_valid[v] && !full_before) begin
        mbuf[v][mcnt[v]] = in_flit[v*FW +: FW];
        mcnt[v]++;
      end
    end
    if (g >= 0) mptr = (g + 1) % NV;
  endtask

  task automatic drive(input int wr_pct, input int rdy_pct);
    for (int v = 0; v < NV; v++) begin
      in_valid[v] = ($urandom % 100) < wr_pct;
      in_flit[v*FW +: FW] = FW'($urandom);
      ds_ready[v] = ($urandom % 100) < rdy_pct;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int v = 0; v < NV; v++) mcnt[v] = 0;
    mptr = 0;
    mopen = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!link_valid, "R1 link_valid", int'(link_valid), 0);
    chk(in_ready == '1, "R1 in_ready", int'(in_ready), (1 << NV) - 1);
    chk(pkt_open == '0, "R1 pkt_open", int'(pkt_open), 0);
    // fill all queues with downstream closed: R3 overflow, R7 idle link
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      drive(100, 0);
      step_and_check();
    end
    // full queues and a write while sending: R3 with R10 collision
    @(negedge clk);
    in_valid = '1;
    ds_ready = '1;
    step_and_check();
    // two VCs ready, no writes: R5 alternation, R6 blocked VC2 ignored
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      in_valid = '0;
      ds_ready = 3'b011;
      step_and_check();
    end
    // random mix
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      drive(55, 60);
      step_and_check();
    end
    // drain
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      in_valid = '0;
      ds_ready = '1;
      step_and_check();
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule